// File: doc/BRIEF.md
# I2C Transaction Sequencer

This block turns one high-level memory request into a complete serial-bus random write or random read. It runs the request as a chain of byte-level primitive commands handed to a lower engine. That engine owns the pin-level clock and data timing. The sequencer decides only the order of the primitives and the byte that goes with each one. It checks the acknowledge of every byte it writes and captures the byte it reads.

A requester presents a mode bit, a device address byte, a high and a low sub-address byte, and a write-data byte. It then raises a valid strobe while the idle flag is high. On acceptance the block latches the whole request and drops its idle flag. It then issues the primitives one at a time. After each one it waits for the engine's completion pulse before issuing the next. A write sends the data byte to the addressed location. A read uses a repeated start to turn the bus around and fetch one byte. If the target refuses any written byte, the sequence is cut short with a stop and an error flag is raised.

Top module: `i2c_txn_seq`

## Requirements
- R1: After reset, req_done is 1, prim_valid is 0, req_err is 0 and rd_data is 0.
- R2: req_done goes low in the cycle after an accepted valid. It stays low through the whole sequence and returns high only in the cycle after the engine completes the final stop.
- R3: One valid assertion starts exactly one transaction, even if valid is held high for several cycles.
- R4: Primitive codes on prim_code are 2'b00 start, 2'b01 stop, 2'b10 write byte and 2'b11 read byte. prim_valid is a single-cycle strobe.
- R5: At most one primitive is outstanding. After a strobe, no further strobe appears until prim_done has been seen.
- R6: Mode 0 issues, in order: start, write device byte, write sub-address high, write sub-address low, write data byte, stop.
- R7: Mode 1 issues, in order: start, write device byte, write sub-address high, write sub-address low, start again, write device byte, read byte, stop. The write-data input has no effect on any primitive.
- R8: The device byte is sent with bit 0 cleared in the address phase. In the read control phase it is sent with bit 0 set, whatever bit 0 the requester supplied.
- R9: If prim_ack is 0 when a write-byte primitive completes, the next primitive is stop. req_err is then 1 once idle. req_err is cleared when the next request is accepted.
- R10: rd_data is loaded from prim_rbyte only when a read-byte primitive completes. It holds its value across writes and failed transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, raised only while req_done is high |
| req_mode | input | 1 | 0 = write, 1 = read |
| req_dev | input | BW | Device address byte |
| req_sub_hi | input | BW | Sub-address high byte |
| req_sub_lo | input | BW | Sub-address low byte |
| req_wdata | input | BW | Byte to write (mode 0 only) |
| req_done | output | 1 | High while idle |
| req_err | output | 1 | Last transaction saw a refused byte |
| rd_data | output | BW | Last byte read |
| prim_valid | output | 1 | One-cycle primitive command strobe |
| prim_code | output | 2 | Primitive code |
| prim_byte | output | BW | Byte for a write primitive |
| prim_done | input | 1 | Engine completion pulse |
| prim_ack | input | 1 | With prim_done: 1 if the written byte was acknowledged |
| prim_rbyte | input | BW | With prim_done: byte returned by a read primitive |

## Verification
The properties assume the requester raises valid only while the block is idle. They also assume the engine pulses prim_done for exactly one cycle, at least one cycle after each strobe and only for a primitive it has accepted. The bench keeps to this by using a reactive engine model. The model answers every strobe a fixed number of cycles later with a single-cycle done pulse. A per-request script picks which primitive index it refuses. Requests are raised only after req_done has been seen high, and valid is held for several cycles on purpose.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    PRIM_START = 2'b00,
    PRIM_STOP  = 2'b01,
    PRIM_WRITE = 2'b10,
    PRIM_READ  = 2'b11
  } prim_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_DEVW, ST_SUBH, ST_SUBL,
    ST_DATA, ST_RSTART, ST_DEVR, ST_READ, ST_STOP
  } step_e;

  function automatic prim_e step_code(input step_e s);
    case (s)
      ST_START, ST_RSTART: step_code = PRIM_START;
      ST_READ:             step_code = PRIM_READ;
      ST_STOP, ST_IDLE:    step_code = PRIM_STOP;
      default:             step_code = PRIM_WRITE;
    endcase
  endfunction

  function automatic logic step_writes(input step_e s);
    step_writes = (step_code(s) == PRIM_WRITE);
  endfunction

  // mode 0 = write, mode 1 = read
  function automatic step_e step_after(input step_e s, input logic rd_mode);
    case (s)
      ST_START:  step_after = ST_DEVW;
      ST_DEVW:   step_after = ST_SUBH;
      ST_SUBH:   step_after = ST_SUBL;
      ST_SUBL:   step_after = rd_mode ? ST_RSTART : ST_DATA;
      ST_DATA:   step_after = ST_STOP;
      ST_RSTART: step_after = ST_DEVR;
      ST_DEVR:   step_after = ST_READ;
      ST_READ:   step_after = ST_STOP;
      default:   step_after = ST_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/i2c_seq_req.sv
module i2c_seq_req #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid,
  input  logic          idle,
  input  logic          mode,
  input  logic [BW-1:0] dev,
  input  logic [BW-1:0] sub_hi,
  input  logic [BW-1:0] sub_lo,
  input  logic [BW-1:0] wdata,
  output logic          accept,
  output logic          h_mode,
  output logic [BW-1:0] h_dev,
  output logic [BW-1:0] h_sub_hi,
  output logic [BW-1:0] h_sub_lo,
  output logic [BW-1:0] h_wdata
);
  logic valid_q;

  // a request is taken only on the rising edge of valid while idle
  assign accept = valid && !valid_q && idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      h_mode   <= 1'b0;
      h_dev    <= '0;
      h_sub_hi <= '0;
      h_sub_lo <= '0;
      h_wdata  <= '0;
    end else begin
      valid_q <= valid;
      if (accept) begin
        h_mode   <= mode;
        h_dev    <= dev;
        h_sub_hi <= sub_hi;
        h_sub_lo <= sub_lo;
        h_wdata  <= wdata;
      end
    end
  end
endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
  import i2c_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  accept,
  input  logic  rd_mode,
  input  logic  prim_done,
  input  logic  prim_ack,
  output step_e step,
  output logic  issue,
  output logic  rd_load,
  output logic  done_o,
  output logic  err_o
);
  logic waiting;

  assign issue   = (step != ST_IDLE) && !waiting;
  assign rd_load = waiting && prim_done && (step == ST_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      step    <= ST_IDLE;
      waiting <= 1'b0;
      done_o  <= 1'b1;
      err_o   <= 1'b0;
    end else if (step == ST_IDLE) begin
      if (accept) begin
        step    <= ST_START;
        waiting <= 1'b0;
        done_o  <= 1'b0;
        err_o   <= 1'b0;
      end
    end else if (!waiting) begin
      waiting <= 1'b1;
    end else if (prim_done) begin
      waiting <= 1'b0;
      if (step == ST_STOP) begin
        step   <= ST_IDLE;
        done_o <= 1'b1;
      end else if (step_writes(step) && !prim_ack) begin
        step  <= ST_STOP;
        err_o <= 1'b1;
      end else begin
        step <= step_after(step, rd_mode);
      end
    end
  end
endmodule

// File: rtl/i2c_seq_cmd.sv
module i2c_seq_cmd
  import i2c_seq_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  step_e             step,
  input  logic [BW-1:0]     dev,
  input  logic [BW-1:0]     sub_hi,
  input  logic [BW-1:0]     sub_lo,
  input  logic [BW-1:0]     wdata,
  input  logic              rd_load,
  input  logic [BW-1:0]     rbyte,
  output logic              prim_valid,
  output logic [CODE_W-1:0] prim_code,
  output logic [BW-1:0]     prim_byte,
  output logic [BW-1:0]     rd_data
);
  localparam logic [BW-1:0] RW_BIT = {{(BW-1){1'b0}}, 1'b1};

  logic [BW-1:0] byte_sel;

  always_comb begin
    case (step)
      ST_DEVW: byte_sel = dev & ~RW_BIT;
      ST_DEVR: byte_sel = dev | RW_BIT;
      ST_SUBH: byte_sel = sub_hi;
      ST_SUBL: byte_sel = sub_lo;
      ST_DATA: byte_sel = wdata;
      default: byte_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prim_valid <= 1'b0;
      prim_code  <= PRIM_STOP;
      prim_byte  <= '0;
      rd_data    <= '0;
    end else begin
      prim_valid <= issue;
      if (issue) begin
        prim_code <= step_code(step);
        prim_byte <= byte_sel;
      end
      if (rd_load) rd_data <= rbyte;
    end
  end
endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
  import i2c_seq_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_mode,
  input  logic [BW-1:0] req_dev,
  input  logic [BW-1:0] req_sub_hi,
  input  logic [BW-1:0] req_sub_lo,
  input  logic [BW-1:0] req_wdata,
  output logic          req_done,
  output logic          req_err,
  output logic [BW-1:0] rd_data,
  output logic          prim_valid,
  output logic [1:0]    prim_code,
  output logic [BW-1:0] prim_byte,
  input  logic          prim_done,
  input  logic          prim_ack,
  input  logic [BW-1:0] prim_rbyte
);
  logic          accept, h_mode, issue, rd_load;
  logic [BW-1:0] h_dev, h_sub_hi, h_sub_lo, h_wdata;
  step_e         step;

  i2c_seq_req #(.BW(BW)) u_req (
    .clk(clk), .rst(rst), .valid(req_valid), .idle(req_done),
    .mode(req_mode), .dev(req_dev), .sub_hi(req_sub_hi),
    .sub_lo(req_sub_lo), .wdata(req_wdata), .accept(accept),
    .h_mode(h_mode), .h_dev(h_dev), .h_sub_hi(h_sub_hi),
    .h_sub_lo(h_sub_lo), .h_wdata(h_wdata)
  );

  i2c_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .accept(accept), .rd_mode(h_mode),
    .prim_done(prim_done), .prim_ack(prim_ack), .step(step),
    .issue(issue), .rd_load(rd_load), .done_o(req_done), .err_o(req_err)
  );

  i2c_seq_cmd #(.BW(BW)) u_cmd (
    .clk(clk), .rst(rst), .issue(issue), .step(step),
    .dev(h_dev), .sub_hi(h_sub_hi), .sub_lo(h_sub_lo), .wdata(h_wdata),
    .rd_load(rd_load), .rbyte(prim_rbyte), .prim_valid(prim_valid),
    .prim_code(prim_code), .prim_byte(prim_byte), .rd_data(rd_data)
  );
endmodule

// File: rtl/i2c_seq_chk.sv
module i2c_seq_chk #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_done,
  input logic          req_err,
  input logic [BW-1:0] rd_data,
  input logic          prim_valid,
  input logic          prim_done,
  input logic          prim_ack
);
  logic valid_prev, pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_prev <= 1'b0;
      pending    <= 1'b0;
    end else begin
      valid_prev <= req_valid;
      if (prim_valid)     pending <= 1'b1;
      else if (prim_done) pending <= 1'b0;
    end
  end

  p_accept_drops_done_r2: assert property (@(posedge clk) disable iff (rst)
    req_done && req_valid && !valid_prev |=> !req_done);

  p_idle_only_after_done_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(req_done) |-> $past(prim_done));

  p_busy_while_strobing_r2: assert property (@(posedge clk) disable iff (rst)
    prim_valid |-> !req_done);

  p_strobe_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    prim_valid |=> !prim_valid);

  p_one_outstanding_r5: assert property (@(posedge clk) disable iff (rst)
    prim_valid |-> !pending);

  p_err_from_refusal_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(req_err) |-> $past(prim_done && !prim_ack));

  p_rdata_held_r10: assert property (@(posedge clk) disable iff (rst)
    !prim_done |=> $stable(rd_data));
endmodule

bind i2c_txn_seq i2c_seq_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_done(req_done),
  .req_err(req_err), .rd_data(rd_data), .prim_valid(prim_valid),
  .prim_done(prim_done), .prim_ack(prim_ack)
);

// File: tb/sim_i2c_txn_seq.sv
module sim_i2c_txn_seq;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 8;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_mode = 1'b0;
  logic [BW-1:0] req_dev = '0, req_sub_hi = '0, req_sub_lo = '0, req_wdata = '0;
  logic          req_done, req_err, prim_valid;
  logic [BW-1:0] rd_data, prim_byte;
  logic [1:0]    prim_code;
  logic          prim_done = 1'b0;
  logic          prim_ack = 1'b0;
  logic [BW-1:0] prim_rbyte = '0;

  int total = 0, bad = 0;
  bit finished = 0;

  // engine model state
  logic [9:0] log_q [16];
  int log_n = 0;
  int nack_at = -1;
  logic [BW-1:0] rd_reply = '0;
  int busy_viol = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_txn_seq #(.BW(BW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_dev(req_dev), .req_sub_hi(req_sub_hi), .req_sub_lo(req_sub_lo),
    .req_wdata(req_wdata), .req_done(req_done), .req_err(req_err),
    .rd_data(rd_data), .prim_valid(prim_valid), .prim_code(prim_code),
    .prim_byte(prim_byte), .prim_done(prim_done), .prim_ack(prim_ack),
    .prim_rbyte(prim_rbyte)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reactive engine: logs each strobe and answers LAT cycles later
  initial begin
    forever begin
      @(negedge clk);
      if (prim_valid) begin
        int idx;
        idx = log_n;
        if (req_done) busy_viol++;
        if (log_n < 16)
          log_q[log_n] = {prim_code, (prim_code == 2'b10) ? prim_byte : 8'h00};
        log_n++;
        repeat (LAT) @(negedge clk);
        if (prim_valid) busy_viol++;
        prim_done  = 1'b1;
        prim_ack   = (idx != nack_at);
        prim_rbyte = rd_reply;
        @(negedge clk);
        prim_done  = 1'b0;
        prim_ack   = 1'b0;
        prim_rbyte = 8'h00;
      end
    end
  end

  task automatic run_req(input logic mode, input logic [7:0] dev, input logic [7:0] sh,
                         input logic [7:0] sl, input logic [7:0] wd,
                         input logic [7:0] rby, input int nk, input string tag);
    int spin;
    log_n = 0; nack_at = nk; rd_reply = rby; busy_viol = 0;
    @(negedge clk);
    req_mode = mode; req_dev = dev; req_sub_hi = sh; req_sub_lo = sl; req_wdata = wd;
    req_valid = 1'b1;
    @(negedge clk);
    check({tag, " R2 done drops after accept"}, {31'd0, req_done}, 32'd0);
    repeat (5) @(negedge clk);   // valid held on purpose (R3)
    req_valid = 1'b0;
    spin = 0;
    while (!req_done && spin < 500) begin @(negedge clk); spin++; end
    check({tag, " R2 returns idle"}, {31'd0, req_done}, 32'd1);
    repeat (12) @(negedge clk);
    check({tag, " R2/R5 no strobe while idle or outstanding"}, busy_viol, 0);
  endtask

  task automatic chk_entry(input string tag, input int i, input logic [1:0] c, input logic [7:0] b);
    check($sformatf("%s entry %0d", tag, i), {22'd0, log_q[i]}, {22'd0, c, b});
  endtask

  task automatic t_reset;
    check("R1 done", {31'd0, req_done}, 32'd1);
    check("R1 strobe", {31'd0, prim_valid}, 32'd0);
    check("R1 err", {31'd0, req_err}, 32'd0);
    check("R1 rd_data", {24'd0, rd_data}, 32'd0);
  endtask

  task automatic t_write;
    run_req(1'b0, 8'hA7, 8'h12, 8'h34, 8'h5C, 8'h00, -1, "wr");
    check("R3 R6 write count", log_n, 6);
    chk_entry("R4 R6 start", 0, 2'b00, 8'h00);
    chk_entry("R6 R8 dev bit0 clear", 1, 2'b10, 8'hA6);
    chk_entry("R6 sub hi", 2, 2'b10, 8'h12);
    chk_entry("R6 sub lo", 3, 2'b10, 8'h34);
    chk_entry("R6 data", 4, 2'b10, 8'h5C);
    chk_entry("R4 R6 stop", 5, 2'b01, 8'h00);
    check("R6 err", {31'd0, req_err}, 32'd0);
  endtask

  task automatic t_read(input logic [7:0] dev, input logic [7:0] rby, input string tag);
    logic [7:0] dw, dr;
    dw = dev & 8'hFE; dr = dev | 8'h01;
    run_req(1'b1, dev, 8'h00, 8'h07, 8'hFF, rby, -1, tag);
    check({tag, " R3 R7 read count"}, log_n, 8);
    chk_entry({tag, " R7 start"}, 0, 2'b00, 8'h00);
    chk_entry({tag, " R8 dev write"}, 1, 2'b10, dw);
    chk_entry({tag, " R7 sub hi"}, 2, 2'b10, 8'h00);
    chk_entry({tag, " R7 sub lo"}, 3, 2'b10, 8'h07);
    chk_entry({tag, " R7 repeated start"}, 4, 2'b00, 8'h00);
    chk_entry({tag, " R8 dev read"}, 5, 2'b10, dr);
    chk_entry({tag, " R4 R7 read byte"}, 6, 2'b11, 8'h00);
    chk_entry({tag, " R7 stop"}, 7, 2'b01, 8'h00);
    check({tag, " R10 rd_data"}, {24'd0, rd_data}, {24'd0, rby});
    check({tag, " R7 err"}, {31'd0, req_err}, 32'd0);
  endtask

  task automatic t_nack_write;
    run_req(1'b0, 8'hA0, 8'h01, 8'h02, 8'h77, 8'h55, 3, "nkw");
    check("R9 nack write count", log_n, 5);
    chk_entry("R9 stop after refused sub lo", 4, 2'b01, 8'h00);
    check("R9 err set", {31'd0, req_err}, 32'd1);
    check("R10 rd_data held after write", {24'd0, rd_data}, 32'h3E);
  endtask

  task automatic t_clear_err;
    run_req(1'b0, 8'hA0, 8'h00, 8'h09, 8'h44, 8'h66, -1, "clr");
    check("R9 err cleared", {31'd0, req_err}, 32'd0);
    check("R6 count", log_n, 6);
    check("R10 rd_data held", {24'd0, rd_data}, 32'h3E);
  endtask

  task automatic t_nack_read;
    run_req(1'b1, 8'hA0, 8'h00, 8'h03, 8'h00, 8'h99, 5, "nkr");
    check("R9 nack read count", log_n, 7);
    chk_entry("R9 refused read control", 5, 2'b10, 8'hA1);
    chk_entry("R9 stop after refusal", 6, 2'b01, 8'h00);
    check("R9 err set on read", {31'd0, req_err}, 32'd1);
    check("R10 rd_data held after failed read", {24'd0, rd_data}, 32'h3E);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_write;
    t_read(8'hA0, 8'h9D, "rd0");
    t_read(8'h51, 8'h3E, "rd1");
    t_nack_write;
    t_clear_err;
    t_nack_read;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule